// File: doc/BRIEF.md
# Six-Channel PWM Generator with Pair Fusion

This block produces six pulse-width modulated outputs from one clock tick. Each of the six channels owns an 8-bit period and an 8-bit duty value and picks, through its own bit, between an edge-aligned waveform and a symmetric (center-aligned) waveform. Neighbouring channels can be fused in pairs (0 with 1, 2 with 3, 4 with 5) into one 16-bit channel. The even channel of a fused pair then supplies the upper byte of the period and duty. The odd channel's pin carries the wide waveform, and the odd channel's alignment bit controls it.

Software programs the block through a plain byte-wide register port: a write strobe with an address and data, and a registered read-data bus that follows the address one cycle later. Period and duty values written mid-cycle wait in a shadow copy and are adopted only when the running cycle ends, so a reprogrammed waveform never shows a runt or stretched pulse.

Top module: `pwm6_concat`

## Requirements
- R1: After reset all six outputs are low and every register reads 0 (all channels separate and edge-aligned).
- R2: Address map: 0 control, 1 alignment, 2 to 7 period of channels 0 to 5, 8 to 13 duty of channels 0 to 5. In the control byte, bit 4 fuses pair 0/1, bit 5 fuses pair 2/3 and bit 6 fuses pair 4/5; the other control bits read 0. Alignment bit n (bits 5..0) selects channel n, 1 = center-aligned; bits 7..6 read 0.
- R3: An edge-aligned channel with period P and duty D (0 < D < P) repeats every P ticks and is high for D ticks of each repeat.
- R4: A center-aligned channel with period P and duty D (0 < D < P) repeats every 2P ticks and is high for 2D ticks of each repeat.
- R5: While a pair is fused, its even channel's pin stays low and its odd channel's pin carries a 16-bit waveform whose period and duty are {even byte, odd byte}.
- R6: A fused pair's waveform follows the odd channel's alignment bit; the even channel's alignment bit has no effect on it.
- R7: A period or duty write takes effect only at the end of the cycle that is running when it is written.
- R8: Duty 0 gives a constant low output; a duty greater than or equal to the period gives a constant high output.
- R9: Setting or clearing a fuse bit restarts the pair's counters from 0 with the current register values, so the fused pin rises within four ticks of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one counter tick |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for writes and reads |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data for the previous cycle's address |
| pwm_o | output | 6 | PWM output pins, bit n is channel n |

## Verification
The bench measures whole waveform repeats edge to edge, so a counter that stops one short or one late, or a center mode that visits its turning points only once, shows up as a wrong high count or a wrong length. It rewrites a duty just after a rising edge and expects the remainder of that repeat to keep the old width; a design that loads values at once would stretch the pulse. Fusing is checked for byte order, for the even pin being forced low, for alignment being taken from the odd bit only, and for a prompt restart; a design without the restart would leave the wide counter at an arbitrary phase and miss the four-tick window. Duty 0 and duty at or above the period are checked as flat lines, which a design with a plain compare would break by one tick each cycle.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int NCH       = 6;
  localparam int NPAIR     = NCH / 2;
  localparam int DW        = 8;
  localparam int AW        = 4;
  localparam int A_CTRL    = 0;
  localparam int A_ALIGN   = 1;
  localparam int PER_BASE  = 2;
  localparam int DUTY_BASE = PER_BASE + NCH;
  localparam int FUSE_LSB  = 4;
endpackage

// File: rtl/pwm6_regs.sv
module pwm6_regs
  import pwm6_pkg::*;
#(
  parameter int N  = NCH,
  parameter int W  = DW,
  parameter int AB = AW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AB-1:0]       addr,
  input  logic [W-1:0]        wdata,
  output logic [W-1:0]        rdata,
  output logic [N/2-1:0]      fuse,
  output logic [N-1:0]        align,
  output logic [N-1:0][W-1:0] per,
  output logic [N-1:0][W-1:0] duty
);
  localparam int NP = N / 2;
  localparam logic [W-1:0] FUSE_MASK = W'(((1 << NP) - 1) << FUSE_LSB);

  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      fuse  <= '0;
      align <= '0;
      per   <= '0;
      duty  <= '0;
    end else if (wr_en) begin
      if (addr == AB'(A_CTRL))  fuse  <= wdata[FUSE_LSB +: NP];
      if (addr == AB'(A_ALIGN)) align <= wdata[N-1:0];
      for (int i = 0; i < N; i++) begin
        if (addr == AB'(PER_BASE + i))  per[i]  <= wdata;
        if (addr == AB'(DUTY_BASE + i)) duty[i] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AB'(A_CTRL))  rd_mux[FUSE_LSB +: NP] = fuse;
    if (addr == AB'(A_ALIGN)) rd_mux[N-1:0] = align;
    for (int i = 0; i < N; i++) begin
      if (addr == AB'(PER_BASE + i))  rd_mux = per[i];
      if (addr == AB'(DUTY_BASE + i)) rd_mux = duty[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R2: unused control bits never show up on the read bus
  p_ctrl_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == AB'(A_CTRL)) |-> ((rdata & ~FUSE_MASK) == '0));
endmodule

// File: rtl/pwm6_engine.sv
module pwm6_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         center,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic         pwm_o
);
  logic [W-1:0] cnt, per_act, duty_act;
  logic         down, at_top, load;

  always_comb begin
    at_top = (per_act == '0) || (cnt >= per_act - W'(1));
    load   = center ? (down && cnt == '0) : at_top;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      down     <= 1'b0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (clr) begin
      cnt      <= '0;
      down     <= 1'b0;
      per_act  <= per_in;
      duty_act <= duty_in;
    end else begin
      if (load) begin
        per_act  <= per_in;
        duty_act <= duty_in;
      end
      if (!center) begin
        down <= 1'b0;
        cnt  <= at_top ? '0 : cnt + W'(1);
      end else if (!down) begin
        if (at_top) down <= 1'b1;
        else        cnt  <= cnt + W'(1);
      end else begin
        if (cnt == '0) down <= 1'b0;
        else           cnt  <= cnt - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      pwm_o <= 1'b0;
    else if (duty_act == '0)      pwm_o <= 1'b0;
    else if (duty_act >= per_act) pwm_o <= 1'b1;
    else                          pwm_o <= (cnt < duty_act);
  end

  // R3: the counter stays inside the active period
  p_cnt_below_period_r3: assert property (@(posedge clk) disable iff (rst)
    (per_act != '0) |-> (cnt < per_act));
  // R7: active values only change at a cycle boundary or restart
  p_hold_between_loads_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr) |=> ($stable(per_act) && $stable(duty_act)));
  // R8: zero duty yields a low output
  p_zero_duty_low_r8: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |=> !pwm_o);
  // R9: a restart puts the counter at 0 on the rising leg
  p_clr_restart_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !down));
endmodule

// File: rtl/pwm6_concat.sv
module pwm6_concat
  import pwm6_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NCH-1:0] pwm_o
);
  logic [NPAIR-1:0]         fuse, fuse_d, restart;
  logic [NCH-1:0]           align;
  logic [NCH-1:0][DW-1:0]   per, duty;

  pwm6_regs #(.N(NCH), .W(DW), .AB(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .fuse(fuse), .align(align), .per(per), .duty(duty)
  );

  always_ff @(posedge clk) begin
    if (rst) fuse_d <= '0;
    else     fuse_d <= fuse;
  end
  assign restart = fuse ^ fuse_d;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int E = 2 * p;
    localparam int O = 2 * p + 1;
    logic ev_raw, od_raw, wide_raw, ev_q, od_q;

    pwm6_engine #(.W(DW)) u_even (
      .clk(clk), .rst(rst), .clr(restart[p]), .center(align[E]),
      .per_in(per[E]), .duty_in(duty[E]), .pwm_o(ev_raw)
    );
    pwm6_engine #(.W(DW)) u_odd (
      .clk(clk), .rst(rst), .clr(restart[p]), .center(align[O]),
      .per_in(per[O]), .duty_in(duty[O]), .pwm_o(od_raw)
    );
    pwm6_engine #(.W(2*DW)) u_wide (
      .clk(clk), .rst(rst), .clr(restart[p]), .center(align[O]),
      .per_in({per[E], per[O]}), .duty_in({duty[E], duty[O]}), .pwm_o(wide_raw)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ev_q <= 1'b0;
        od_q <= 1'b0;
      end else begin
        ev_q <= fuse[p] ? 1'b0 : ev_raw;
        od_q <= fuse[p] ? wide_raw : od_raw;
      end
    end
    assign pwm_o[E] = ev_q;
    assign pwm_o[O] = od_q;

    // R5: the even pin of a fused pair is held low
    p_even_held_low_r5: assert property (@(posedge clk) disable iff (rst)
      $past(fuse[p]) |-> !pwm_o[E]);
  end
endmodule

// File: tb/sim_pwm6_concat.sv
module sim_pwm6_concat;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] pwm_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwm6_concat u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 4'(a);
    @(negedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_rise(input int ch);
    logic prev, cur;
    cur = pwm_o[ch];
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      prev = cur; cur = pwm_o[ch];
      if (!prev && cur) return;
    end
  endtask

  // counts ticks and high ticks from the current negedge to the next rise
  task automatic run_to_rise(input int ch, output int hi, output int len);
    logic prev, cur;
    hi = 0; len = 0; cur = pwm_o[ch];
    for (int i = 0; i < 5000; i++) begin
      hi += int'(cur); len++;
      @(negedge clk);
      prev = cur; cur = pwm_o[ch];
      if (!prev && cur) return;
    end
  endtask

  task automatic measure(input int ch, output int hi, output int len);
    for (int k = 0; k < 3; k++) begin
      wait_rise(ch);
      run_to_rise(ch, hi, len);
    end
  endtask

  task automatic high_count(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_o[ch]);
    end
  endtask

  task automatic t_reset();
    int d;
    chk("R1", "pins after reset", int'(pwm_o), 0);
    rd(0, d); chk("R1", "control after reset", d, 0);
    rd(1, d); chk("R1", "alignment after reset", d, 0);
    rd(2, d); chk("R1", "period ch0 after reset", d, 0);
    rd(13, d); chk("R1", "duty ch5 after reset", d, 0);
  endtask

  task automatic t_regs();
    int d;
    wr(0, 8'hFF); rd(0, d); chk("R2", "control readback", d, 8'h70);
    wr(0, 8'h00); rd(0, d); chk("R2", "control cleared", d, 0);
    wr(1, 8'hFF); rd(1, d); chk("R2", "alignment readback", d, 8'h3F);
    wr(1, 8'h00);
    wr(9, 8'hA5); rd(9, d); chk("R2", "duty ch1 readback", d, 8'hA5);
    wr(9, 8'h00);
  endtask

  task automatic t_left();
    int hi, len;
    wr(2 + 2, 10); wr(8 + 2, 3);
    wr(2 + 3, 7);  wr(8 + 3, 5);
    measure(2, hi, len);
    chk("R3", "ch2 high ticks", hi, 3); chk("R3", "ch2 repeat", len, 10);
    measure(3, hi, len);
    chk("R3", "ch3 high ticks", hi, 5); chk("R3", "ch3 repeat", len, 7);
  endtask

  task automatic t_center();
    int hi, len;
    wr(1, 8'h04);
    measure(2, hi, len);
    chk("R4", "ch2 center high ticks", hi, 6); chk("R4", "ch2 center repeat", len, 20);
    wr(1, 8'h00);
  endtask

  task automatic t_limits();
    int hi;
    wr(2 + 4, 10); wr(8 + 4, 0);
    repeat (30) @(negedge clk);
    high_count(4, 40, hi); chk("R8", "duty 0 high ticks", hi, 0);
    wr(8 + 4, 10);
    repeat (30) @(negedge clk);
    high_count(4, 40, hi); chk("R8", "duty = period high ticks", hi, 40);
    wr(8 + 4, 200);
    repeat (30) @(negedge clk);
    high_count(4, 40, hi); chk("R8", "duty > period high ticks", hi, 40);
  endtask

  task automatic t_glitch();
    int hi, len;
    measure(2, hi, len);
    wait_rise(2);
    wr(8 + 2, 9);
    run_to_rise(2, hi, len);
    chk("R7", "rest of cycle high ticks", hi, 1);
    chk("R7", "rest of cycle ticks", len, 8);
    run_to_rise(2, hi, len);
    chk("R7", "next cycle high ticks", hi, 9);
    chk("R7", "next cycle repeat", len, 10);
  endtask

  task automatic t_fuse();
    int hi, len, t;
    wr(2 + 0, 3); wr(8 + 0, 1);
    wr(2 + 1, 0); wr(8 + 1, 0);
    repeat (10) @(negedge clk);
    high_count(1, 20, hi); chk("R5", "ch1 low before fuse", hi, 0);
    wr(0, 8'h10);
    t = 0;
    while (!pwm_o[1] && t < 100) begin @(negedge clk); t++; end
    checks++;
    if (t > 4) begin
      fails++;
      $display("FAIL R9 ticks to first rise: actual %0d expected <= 4", t);
    end
    measure(1, hi, len);
    chk("R5", "fused high ticks", hi, 256); chk("R5", "fused repeat", len, 768);
    high_count(0, 100, hi); chk("R5", "even pin while fused", hi, 0);
    wr(1, 8'h02);
    measure(1, hi, len);
    chk("R6", "fused center high ticks", hi, 512); chk("R6", "fused center repeat", len, 1536);
    wr(1, 8'h01);
    measure(1, hi, len);
    chk("R6", "even align ignored high", hi, 256); chk("R6", "even align ignored repeat", len, 768);
    wr(1, 8'h00);
    wr(0, 8'h00);
    measure(0, hi, len);
    chk("R5", "ch0 after unfuse high", hi, 1); chk("R5", "ch0 after unfuse repeat", len, 3);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_left();
    t_center();
    t_limits();
    t_glitch();
    t_fuse();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule